// File: doc/BRIEF.md
# Panel RAM Window Command Generator

This block turns a pixel rectangle on an 800 by 480 electrophoretic panel into the byte sequence an external panel controller needs before pixel data can be streamed into its frame RAM. Given the rectangle origin and size, it computes a window whose rows are mirrored top to bottom, because the panel's gate lines scan upward. It then emits the addressing-direction setting, the column and row window limits and the initial address counters, one byte per handshake, each tagged as a command or a data byte.

The sequence can optionally end with the write-RAM command that selects the buffer for the following pixel bytes. That is either the buffer holding the new image or the buffer holding the previous image, which the controller uses for differential refresh. When the last byte is accepted, the block pulses a completion flag and reports how many pixel bytes the caller must send next. A rectangle that cannot be addressed is rejected with an error pulse, and no byte is emitted for it.

Top module: `epd_win_seq`

## Requirements
- R1: While reset is asserted, and after its release until a start is accepted, `out_valid`, `done` and `err` are low.
- R2: An accepted rectangle's stream begins with command byte 0x11 followed by data byte 0x01, which selects column increment with row decrement.
- R3: Command 0x44 follows. It carries four data bytes: the column start x, then the column end x+w-1, both in pixel units and each sent low byte first, then high byte.
- R4: Command 0x45 follows. With yr = 480-y-h, it carries the row start yr+h-1 and then the row end yr, each sent low byte first, then high byte.
- R5: Command 0x4E with x (low byte, high byte) follows, then command 0x4F with yr+h-1 (low byte, high byte). This makes 18 bytes in total.
- R6: When `wr_append` is high at start, a 19th byte follows: command 0x24 if `wr_prev` is low, or command 0x26 if `wr_prev` is high. When `wr_append` is low, the stream ends after the 18th byte.
- R7: `out_is_cmd` is high on exactly the command bytes 0x11, 0x44, 0x45, 0x4E, 0x4F, 0x24 and 0x26, and low on every data byte.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_byte` and `out_is_cmd` hold their values into the next cycle.
- R9: `done` is high for exactly one cycle, the cycle after the final byte is accepted. In that cycle `payload_bytes` equals w*h/8, and it holds that value until the next valid rectangle is accepted.
- R10: A start is rejected in any of these cases: x or w is not a multiple of 8, w or h is zero, x+w exceeds 800, or y+h exceeds 480. A rejected start pulses `err` for one cycle, in the cycle after the start, and produces no output byte and no `done`.
- R11: A start raised while a stream is in progress is ignored, and the stream in progress is not altered. A start present in the `done` cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to process the rectangle on the rect inputs |
| rect_x | input | 10 | Left column of the rectangle, in pixels |
| rect_y | input | 9 | Top row of the rectangle, in pixels |
| rect_w | input | 10 | Width of the rectangle, in pixels |
| rect_h | input | 9 | Height of the rectangle, in pixels |
| wr_append | input | 1 | Append a write-RAM command to the stream |
| wr_prev | input | 1 | Select the previous-image buffer for the appended command |
| out_valid | output | 1 | Byte available on out_byte |
| out_ready | input | 1 | Consumer accepts the byte |
| out_byte | output | 8 | Command or data byte |
| out_is_cmd | output | 1 | High for a command byte, low for a data byte |
| done | output | 1 | One-cycle pulse after the final byte is accepted |
| err | output | 1 | One-cycle pulse for a rejected rectangle |
| payload_bytes | output | 16 | Pixel byte count w*h/8 for the accepted rectangle |

## Verification
A new start request can coincide with the acceptance of the final byte, or can arrive in the completion cycle that follows it. Both are provoked by holding `start` high continuously, with a second rectangle placed on the inputs once the first is accepted. The check passes when the captured stream is exactly the first rectangle's bytes followed by the second's, with two completion pulses, no duplicated stream and no error. A separate start pulse in the middle of a stream must leave that stream byte-identical and produce no further bytes.

// File: rtl/epd_win_pkg.sv
package epd_win_pkg;
  localparam int CW = 16;

  localparam logic [7:0] CMD_ENTRY   = 8'h11;
  localparam logic [7:0] ENTRY_XI_YD = 8'h01;
  localparam logic [7:0] CMD_XWIN    = 8'h44;
  localparam logic [7:0] CMD_YWIN    = 8'h45;
  localparam logic [7:0] CMD_XCNT    = 8'h4E;
  localparam logic [7:0] CMD_YCNT    = 8'h4F;
  localparam logic [7:0] CMD_WR_NEW  = 8'h24;
  localparam logic [7:0] CMD_WR_OLD  = 8'h26;

  localparam int BASE_LEN = 18;

  typedef struct packed {
    logic [CW-1:0] xs;
    logic [CW-1:0] xe;
    logic [CW-1:0] ys;
    logic [CW-1:0] ye;
  } win_t;

  typedef enum logic [0:0] {ST_IDLE, ST_EMIT} seq_st_t;
endpackage

// File: rtl/epd_win_calc.sv
module epd_win_calc
  import epd_win_pkg::*;
#(
  parameter int PANEL_W = 800,
  parameter int PANEL_H = 480,
  parameter int XW = 10,
  parameter int YW = 9,
  parameter int PW = 16
) (
  input  logic [XW-1:0] x,
  input  logic [XW-1:0] w,
  input  logic [YW-1:0] y,
  input  logic [YW-1:0] h,
  output win_t          win,
  output logic          ok,
  output logic [PW-1:0] payload
);
  logic [CW-1:0] x16, w16, y16, h16, xsum, ysum, yrev;
  logic aligned, nonempty, fits;

  always_comb begin
    x16      = CW'(x);
    w16      = CW'(w);
    y16      = CW'(y);
    h16      = CW'(h);
    xsum     = x16 + w16;
    ysum     = y16 + h16;
    aligned  = (x[2:0] == 3'b000) && (w[2:0] == 3'b000);
    nonempty = (w16 != '0) && (h16 != '0);
    fits     = (xsum <= CW'(PANEL_W)) && (ysum <= CW'(PANEL_H));
    ok       = aligned && nonempty && fits;
    // mirrored row origin: gates scan from the bottom edge
    yrev     = CW'(PANEL_H) - ysum;
    win.xs   = x16;
    win.xe   = xsum - CW'(1);
    win.ys   = yrev + h16 - CW'(1);
    win.ye   = yrev;
    payload  = PW'((w16 >> 3) * h16);
  end
endmodule

// File: rtl/epd_win_bytes.sv
module epd_win_bytes
  import epd_win_pkg::*;
#(
  parameter int IW = 5
) (
  input  logic [IW-1:0] idx,
  input  win_t          win,
  input  logic          wr_prev,
  output logic [7:0]    obyte,
  output logic          ocmd
);
  always_comb begin
    obyte = 8'h00;
    ocmd  = 1'b0;
    case (idx)
      IW'(0):  begin obyte = CMD_ENTRY; ocmd = 1'b1; end
      IW'(1):  obyte = ENTRY_XI_YD;
      IW'(2):  begin obyte = CMD_XWIN; ocmd = 1'b1; end
      IW'(3):  obyte = win.xs[7:0];
      IW'(4):  obyte = win.xs[15:8];
      IW'(5):  obyte = win.xe[7:0];
      IW'(6):  obyte = win.xe[15:8];
      IW'(7):  begin obyte = CMD_YWIN; ocmd = 1'b1; end
      IW'(8):  obyte = win.ys[7:0];
      IW'(9):  obyte = win.ys[15:8];
      IW'(10): obyte = win.ye[7:0];
      IW'(11): obyte = win.ye[15:8];
      IW'(12): begin obyte = CMD_XCNT; ocmd = 1'b1; end
      IW'(13): obyte = win.xs[7:0];
      IW'(14): obyte = win.xs[15:8];
      IW'(15): begin obyte = CMD_YCNT; ocmd = 1'b1; end
      IW'(16): obyte = win.ys[7:0];
      IW'(17): obyte = win.ys[15:8];
      IW'(18): begin obyte = wr_prev ? CMD_WR_OLD : CMD_WR_NEW; ocmd = 1'b1; end
      default: begin obyte = 8'h00; ocmd = 1'b0; end
    endcase
  end
endmodule

// File: rtl/epd_win_seq.sv
module epd_win_seq
  import epd_win_pkg::*;
#(
  parameter int PANEL_W = 800,
  parameter int PANEL_H = 480,
  localparam int XW = $clog2(PANEL_W + 1),
  localparam int YW = $clog2(PANEL_H + 1),
  localparam int PW = $clog2(PANEL_W * PANEL_H / 8 + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [XW-1:0] rect_x,
  input  logic [YW-1:0] rect_y,
  input  logic [XW-1:0] rect_w,
  input  logic [YW-1:0] rect_h,
  input  logic          wr_append,
  input  logic          wr_prev,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_byte,
  output logic          out_is_cmd,
  output logic          done,
  output logic          err,
  output logic [PW-1:0] payload_bytes
);
  localparam int IW = $clog2(BASE_LEN + 2);

  seq_st_t       st_q, st_d;
  logic [IW-1:0] idx_q, idx_d, last_idx;
  win_t          win_c, win_q;
  logic          ok_c, load_en, fire;
  logic [PW-1:0] pay_c, pay_q;
  logic          app_q, prev_q;
  logic          done_q, done_d, err_q, err_d;

  epd_win_calc #(
    .PANEL_W(PANEL_W), .PANEL_H(PANEL_H), .XW(XW), .YW(YW), .PW(PW)
  ) u_calc (
    .x(rect_x), .w(rect_w), .y(rect_y), .h(rect_h),
    .win(win_c), .ok(ok_c), .payload(pay_c)
  );

  epd_win_bytes #(.IW(IW)) u_bytes (
    .idx(idx_q), .win(win_q), .wr_prev(prev_q),
    .obyte(out_byte), .ocmd(out_is_cmd)
  );

  always_comb begin
    st_d     = st_q;
    idx_d    = idx_q;
    done_d   = 1'b0;
    err_d    = 1'b0;
    load_en  = 1'b0;
    last_idx = app_q ? IW'(BASE_LEN) : IW'(BASE_LEN - 1);
    fire     = (st_q == ST_EMIT) && out_ready;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          if (ok_c) begin
            load_en = 1'b1;
            st_d    = ST_EMIT;
            idx_d   = '0;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      ST_EMIT: begin
        if (fire) begin
          if (idx_q == last_idx) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end else begin
            idx_d = idx_q + IW'(1);
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      pay_q  <= '0;
      app_q  <= 1'b0;
      prev_q <= 1'b0;
    end else if (load_en) begin
      win_q  <= win_c;
      pay_q  <= pay_c;
      app_q  <= wr_append;
      prev_q <= wr_prev;
    end
  end

  assign out_valid     = (st_q == ST_EMIT);
  assign done          = done_q;
  assign err           = err_q;
  assign payload_bytes = pay_q;
endmodule

// File: rtl/epd_win_seq_chk.sv
module epd_win_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_byte,
  input logic       out_is_cmd,
  input logic       done,
  input logic       err
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_is_cmd))); // R8

  AST_STREAM_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (out_is_cmd && out_byte == 8'h11)); // R2

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_DONE_AFTER_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(out_valid && out_ready)); // R9

  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!out_valid && !done)); // R10

  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err); // R10
endmodule

bind epd_win_seq epd_win_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_byte(out_byte), .out_is_cmd(out_is_cmd), .done(done), .err(err)
);

// File: tb/epd_win_seq_tb.sv
module epd_win_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [9:0] rect_x = '0, rect_w = '0;
  logic [8:0] rect_y = '0, rect_h = '0;
  logic       wr_append = 1'b0, wr_prev = 1'b0;
  logic       out_valid, out_is_cmd, done, err;
  logic       out_ready = 1'b1;
  logic [7:0] out_byte;
  logic [15:0] payload_bytes;

  int checks = 0, errors = 0;
  bit rnd_ready = 0;
  logic [7:0] lfsr = 8'hA5;

  logic [7:0] cap_b [0:63];
  logic       cap_c [0:63];
  int cap_n = 0, done_n = 0, err_n = 0;
  logic [15:0] pay_seen = '0;
  bit hs_prev = 0, done_hs = 0;
  bit stall_prev = 0;
  logic [7:0] pb;
  logic pc;

  logic [7:0] exp_b [0:63];
  logic       exp_c [0:63];
  int exp_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  epd_win_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .rect_x(rect_x), .rect_y(rect_y), .rect_w(rect_w), .rect_h(rect_h),
    .wr_append(wr_append), .wr_prev(wr_prev),
    .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
    .out_is_cmd(out_is_cmd), .done(done), .err(err), .payload_bytes(payload_bytes)
  );

  task automatic fail(input string req, input string what, input int act, input int expv);
    errors++;
    $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
  endtask

  task automatic chk(input string req, input string what, input int act, input int expv);
    checks++;
    if (act != expv) fail(req, what, act, expv);
  endtask

  always @(posedge clk) begin
    #1;
    if (rnd_ready) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = lfsr[0] | lfsr[2];
    end else begin
      out_ready = 1'b1;
    end
  end

  // monitor, sampling away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_prev) begin
        checks++;
        if (!(out_valid && out_byte == pb && out_is_cmd == pc))
          fail("R8", "byte changed under stall", int'(out_byte), int'(pb));
      end
      stall_prev = out_valid && !out_ready;
      pb = out_byte;
      pc = out_is_cmd;
      if (done) begin
        done_n++;
        pay_seen = payload_bytes;
        done_hs = hs_prev;
      end
      if (err) err_n++;
      hs_prev = out_valid && out_ready;
      if (out_valid && out_ready && cap_n < 64) begin
        cap_b[cap_n] = out_byte;
        cap_c[cap_n] = out_is_cmd;
        cap_n++;
      end
    end
  end

  task automatic clear_all();
    cap_n = 0; done_n = 0; err_n = 0; exp_n = 0;
  endtask

  task automatic push(input logic c, input logic [7:0] b);
    exp_b[exp_n] = b;
    exp_c[exp_n] = c;
    exp_n++;
  endtask

  task automatic build(input int x, input int y, input int w, input int h,
                       input bit app, input bit prv);
    int yr, ys, xe;
    yr = 480 - y - h;
    ys = yr + h - 1;
    xe = x + w - 1;
    push(1, 8'h11); push(0, 8'h01);
    push(1, 8'h44); push(0, x[7:0]); push(0, x[15:8]); push(0, xe[7:0]); push(0, xe[15:8]);
    push(1, 8'h45); push(0, ys[7:0]); push(0, ys[15:8]); push(0, yr[7:0]); push(0, yr[15:8]);
    push(1, 8'h4E); push(0, x[7:0]); push(0, x[15:8]);
    push(1, 8'h4F); push(0, ys[7:0]); push(0, ys[15:8]);
    if (app) push(1, prv ? 8'h26 : 8'h24);
  endtask

  function automatic string req_of(input int i);
    if (i < 2) return "R2";
    if (i < 7) return "R3";
    if (i < 12) return "R4";
    if (i < 18) return "R5";
    return "R6";
  endfunction

  task automatic compare_stream();
    chk("R6", "stream length", cap_n, exp_n);
    for (int i = 0; i < exp_n && i < cap_n; i++) begin
      chk(req_of(i % 19 < 18 ? i % 19 : 18), $sformatf("byte %0d", i), int'(cap_b[i]), int'(exp_b[i]));
      chk("R7", $sformatf("cmd flag %0d", i), int'(cap_c[i]), int'(exp_c[i]));
    end
  endtask

  task automatic set_rect(input int x, input int y, input int w, input int h,
                          input bit app, input bit prv);
    rect_x = x[9:0]; rect_y = y[8:0]; rect_w = w[9:0]; rect_h = h[8:0];
    wr_append = app; wr_prev = prv;
  endtask

  task automatic wait_done(input int n);
    int cnt = 0;
    while (done_n < n && cnt < 3000) begin
      @(negedge clk);
      cnt++;
    end
    if (done_n < n) fail("R9", "timeout waiting for done", done_n, n);
  endtask

  task automatic run_good(input int x, input int y, input int w, input int h,
                          input bit app, input bit prv, input bit rnd);
    clear_all();
    rnd_ready = rnd;
    build(x, y, w, h, app, prv);
    set_rect(x, y, w, h, app, prv);
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    wait_done(1);
    repeat (3) @(negedge clk);
    compare_stream();
    chk("R9", "done count", done_n, 1);
    chk("R9", "handshake before done", int'(done_hs), 1);
    chk("R9", "payload bytes", int'(pay_seen), (w / 8) * h);
    chk("R9", "payload held", int'(payload_bytes), (w / 8) * h);
    chk("R10", "no err for good rect", err_n, 0);
    rnd_ready = 0;
  endtask

  task automatic run_bad(input int x, input int y, input int w, input int h, input string tag);
    clear_all();
    set_rect(x, y, w, h, 1, 0);
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    @(negedge clk);
    chk("R10", {tag, " err next cycle"}, int'(err), 1);
    repeat (25) @(negedge clk);
    chk("R10", {tag, " err pulses"}, err_n, 1);
    chk("R10", {tag, " no bytes"}, cap_n, 0);
    chk("R10", {tag, " no done"}, done_n, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "valid in reset", int'(out_valid), 0);
    chk("R1", "done in reset", int'(done), 0);
    chk("R1", "err in reset", int'(err), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "valid after reset", int'(out_valid), 0);
    chk("R1", "done/err after reset", int'(done | err), 0);
  endtask

  task automatic t_midstream_start();
    clear_all();
    build(64, 32, 128, 64, 1, 0);
    set_rect(64, 32, 128, 64, 1, 0);
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    while (cap_n < 4) @(negedge clk);
    @(posedge clk); #1 begin set_rect(8, 8, 16, 16, 0, 1); start = 1'b1; end
    @(posedge clk); #1 start = 1'b0;
    wait_done(1);
    repeat (25) @(negedge clk);
    compare_stream();
    chk("R11", "single done for busy start", done_n, 1);
    chk("R11", "no extra stream", cap_n, 19);
  endtask

  task automatic t_chain();
    clear_all();
    build(0, 0, 16, 8, 1, 1);
    build(400, 200, 80, 100, 0, 0);
    set_rect(0, 0, 16, 8, 1, 1);
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 set_rect(400, 200, 80, 100, 0, 0);
    while (done_n < 1) @(negedge clk);
    @(posedge clk); #1 start = 1'b0;
    wait_done(2);
    repeat (25) @(negedge clk);
    compare_stream();
    chk("R11", "two dones in chain", done_n, 2);
    chk("R11", "chain payload", int'(pay_seen), 10 * 100);
    chk("R11", "no err in chain", err_n, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fail("WD", "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    t_reset();
    run_good(0, 0, 800, 480, 1, 0, 0);
    run_good(96, 100, 200, 40, 1, 1, 1);
    run_good(792, 472, 8, 8, 0, 0, 1);
    run_good(256, 0, 512, 479, 1, 0, 0);
    run_bad(4, 0, 16, 16, "x unaligned");
    run_bad(0, 0, 12, 16, "w unaligned");
    run_bad(720, 0, 88, 16, "x+w over");
    run_bad(0, 400, 16, 81, "y+h over");
    run_bad(0, 0, 0, 16, "zero w");
    run_bad(0, 0, 16, 0, "zero h");
    t_midstream_start();
    t_chain();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule